// File: doc/BRIEF.md
# Fetch Queue with Loop Replay

This block sits between instruction fetch and decode. Fetch offers a group of up to four instructions per cycle. The queue holds them in program order and shows up to four of the oldest to decode each cycle. Lane 0 always carries the oldest instruction.

The queue also acts as a small loop cache. Suppose the same backward taken branch shows up in two consecutive branch-ending groups with the same target, and the first copy of the target instruction is still unread. The block then freezes the body, from that target through the second branch, inside the queue. Entries older than the body drain as usual. After that, decode sees the body repeated for as long as needed.

While the body is replayed, the block accepts no fetch input and raises a signal telling fetch to leave the instruction cache idle. A flush clears the queue and leaves replay mode, for example on a misprediction or when the loop exits. Normal fetch then resumes.

Top module: `fetch_loop_buf`

## Requirements
- R1: While `rst_ni` is low, and right after it is released, no decode lane is valid, `fetch_ready_o` is 1 and `icache_bypass_o` is 0.
- R2: A fetch group is written only in a cycle with `fetch_ready_o` high. Outside replay, `fetch_ready_o` is high exactly when at least four of the 32 entries are free. The group's lanes are the set bits of `fetch_valid_i`, contiguous from lane 0, and lane 0 is the oldest.
- R3: Outside replay, decode lanes 0..k-1 are valid, with k = min(4, occupancy), and they hold the oldest entries in order. `dec_ready_i` high consumes all k.
- R4: The sequence seen at decode equals the sequence of accepted fetch lanes: same PCs, same instruction words, same order.
- R5: A group offered while `fetch_ready_o` is low is dropped and never reaches decode.
- R6: `fetch_taken_i` marks the last valid lane as a taken branch to `fetch_target_i`. The branch is backward when the target is at or below its PC. Replay starts in the cycle after an accepted group whose branch has the same PC and target as the candidate. The candidate is the most recent accepted taken branch, and it must have been backward. In that cycle `icache_bypass_o` becomes 1 and `fetch_ready_o` becomes 0.
- R7: In replay, all four decode lanes are valid. After the entries older than the body drain, the body (target through branch) repeats without a gap. This includes bodies shorter than four, which wrap within one output cycle.
- R8: An accepted taken branch whose target is above its PC clears the candidate. The next backward sighting does not start replay.
- R9: If decode has already consumed the instruction that followed the first sighting, a second sighting does not start replay.
- R10: `flush_i` wins over fetch and decode in the same cycle. In the next cycle the queue is empty, replay is off and fetch is ready.
- R11: During replay, fetch input has no effect on the decode stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empties the queue and ends replay |
| fetch_valid_i | input | 4 | Lane valid mask, contiguous from lane 0 |
| fetch_insn_i | input | 128 | Instruction words, lane j at bits 32j+31:32j |
| fetch_pc_i | input | 128 | Lane PCs, same packing |
| fetch_taken_i | input | 1 | Last valid lane is a taken branch |
| fetch_target_i | input | 32 | Target PC of that branch |
| fetch_ready_o | output | 1 | Group will be accepted this cycle |
| dec_valid_o | output | 4 | Decode lane valid mask |
| dec_insn_o | output | 128 | Instruction words to decode |
| dec_pc_o | output | 128 | PCs to decode |
| dec_ready_i | input | 1 | Decode consumes all valid lanes |
| icache_bypass_o | output | 1 | Replay active; fetch should not read the cache |

## Verification
Two events can land in the same cycle: the second loop sighting being written, and decode draining entries that the loop check depends on. A further case is a flush arriving together with a fetch group and a decode pop.

The bench builds each case directly. It gives the target instruction its own group and drains that group before the second sighting. It also raises flush in the same cycle as a valid group and `dec_ready_i`.

In the following cycle the bench judges the outcome at the ports. It checks whether replay started, and that the discarded group never appears at decode.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
  typedef enum logic {
    MODE_STREAM = 1'b0,
    MODE_REPLAY = 1'b1
  } fbuf_mode_e;
endpackage

// File: rtl/fbuf_store.sv
module fbuf_store #(
  parameter int DEPTH  = 32,
  parameter int LANES  = 4,
  parameter int PC_W   = 32,
  parameter int INSN_W = 32,
  parameter int SEQ_W  = 6,
  parameter int CNT_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [SEQ_W-1:0]        wr_seq_i,
  input  logic [CNT_W-1:0]        wr_cnt_i,
  input  logic [LANES*INSN_W-1:0] insn_i,
  input  logic [LANES*PC_W-1:0]   pc_i,
  input  logic [LANES*SEQ_W-1:0]  rd_pos_i,
  output logic [LANES*INSN_W-1:0] rd_insn_o,
  output logic [LANES*PC_W-1:0]   rd_pc_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [INSN_W-1:0] insn_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IDX_W-1:0] widx;
    logic [IDX_W-1:0] ridx;
    assign widx = wr_seq_i[IDX_W-1:0] + IDX_W'(j);
    assign ridx = rd_pos_i[j*SEQ_W +: IDX_W];

    always_ff @(posedge clk_i) begin
      if (we_i && (CNT_W'(j) < wr_cnt_i)) begin
        insn_q[widx] <= insn_i[j*INSN_W +: INSN_W];
        pc_q[widx]   <= pc_i[j*PC_W +: PC_W];
      end
    end

    assign rd_insn_o[j*INSN_W +: INSN_W] = insn_q[ridx];
    assign rd_pc_o[j*PC_W +: PC_W]       = pc_q[ridx];
  end
endmodule

// File: rtl/fbuf_rd_walk.sv
module fbuf_rd_walk #(
  parameter int LANES = 4,
  parameter int SEQ_W = 6
) (
  input  logic [SEQ_W-1:0]           rd_i,
  input  logic                       replay_i,
  input  logic [SEQ_W-1:0]           start_i,
  input  logic [SEQ_W-1:0]           end_i,
  output logic [(LANES+1)*SEQ_W-1:0] pos_o
);
  assign pos_o[SEQ_W-1:0] = rd_i;

  // each step wraps from the body end back to its start while replaying
  for (genvar j = 0; j < LANES; j++) begin : g_step
    logic [SEQ_W-1:0] cur;
    assign cur = pos_o[j*SEQ_W +: SEQ_W];
    assign pos_o[(j+1)*SEQ_W +: SEQ_W] =
      (replay_i && cur == end_i) ? start_i : cur + SEQ_W'(1);
  end
endmodule

// File: rtl/fbuf_loop_ctl.sv
module fbuf_loop_ctl
  import fbuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PC_W  = 32,
  parameter int SEQ_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             grp_acc_i,
  input  logic [PC_W-1:0]  br_pc_i,
  input  logic             taken_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic [SEQ_W-1:0] wr_nxt_i,
  input  logic [SEQ_W-1:0] rd_q_i,
  input  logic [SEQ_W-1:0] occ_q_i,
  input  logic [SEQ_W-1:0] rd_nxt_i,
  input  logic [SEQ_W-1:0] occ_nxt_i,
  output fbuf_mode_e       mode_o,
  output logic [SEQ_W-1:0] body_start_o,
  output logic [SEQ_W-1:0] body_end_o
);
  logic             cand_vld_q;
  logic [PC_W-1:0]  cand_pc_q, cand_tgt_q;
  logic [SEQ_W-1:0] cand_seq_q;
  fbuf_mode_e       mode_q;
  logic [SEQ_W-1:0] start_q, end_q;

  logic [SEQ_W-1:0] dist_now, dist_nxt;
  logic             cand_gone, backward, hit;

  // candidate seq must lie between the read pointer and the write pointer
  assign dist_now  = cand_seq_q - rd_q_i;
  assign dist_nxt  = cand_seq_q - rd_nxt_i;
  assign cand_gone = cand_vld_q && (dist_now > occ_q_i);
  assign backward  = target_i <= br_pc_i;
  assign hit = grp_acc_i && taken_i && backward && cand_vld_q && !cand_gone &&
               (br_pc_i == cand_pc_q) && (target_i == cand_tgt_q) &&
               (dist_nxt < occ_nxt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= MODE_STREAM;
      start_q    <= '0;
      end_q      <= '0;
      cand_vld_q <= 1'b0;
      cand_pc_q  <= '0;
      cand_tgt_q <= '0;
      cand_seq_q <= '0;
    end else if (flush_i) begin
      mode_q     <= MODE_STREAM;
      cand_vld_q <= 1'b0;
    end else if (hit) begin
      mode_q     <= MODE_REPLAY;
      start_q    <= cand_seq_q;
      end_q      <= wr_nxt_i - SEQ_W'(1);
      cand_vld_q <= 1'b0;
    end else if (grp_acc_i && taken_i) begin
      cand_vld_q <= backward;
      cand_pc_q  <= br_pc_i;
      cand_tgt_q <= target_i;
      cand_seq_q <= wr_nxt_i;
    end else if (cand_gone) begin
      cand_vld_q <= 1'b0;
    end
  end

  assign mode_o       = mode_q;
  assign body_start_o = start_q;
  assign body_end_o   = end_q;

  // R6
  body_fits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_REPLAY |-> (end_q - start_q) < SEQ_W'(DEPTH));

  // R7
  replay_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_REPLAY && !flush_i) |=> mode_q == MODE_REPLAY);
endmodule

// File: rtl/fetch_loop_buf.sv
module fetch_loop_buf
  import fbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int LANES  = 4,
  parameter int PC_W   = 32,
  parameter int INSN_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic [LANES-1:0]        fetch_valid_i,
  input  logic [LANES*INSN_W-1:0] fetch_insn_i,
  input  logic [LANES*PC_W-1:0]   fetch_pc_i,
  input  logic                    fetch_taken_i,
  input  logic [PC_W-1:0]         fetch_target_i,
  output logic                    fetch_ready_o,
  output logic [LANES-1:0]        dec_valid_o,
  output logic [LANES*INSN_W-1:0] dec_insn_o,
  output logic [LANES*PC_W-1:0]   dec_pc_o,
  input  logic                    dec_ready_i,
  output logic                    icache_bypass_o
);
  localparam int SEQ_W = $clog2(DEPTH) + 1;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam logic [SEQ_W-1:0] FILL_LIM = SEQ_W'(DEPTH - LANES);

  logic [SEQ_W-1:0] wr_q, rd_q, occ_q, wr_nxt, rd_nxt, occ_nxt;
  logic [CNT_W-1:0] cnt_in, avail, pop_n;
  logic             grp_acc;
  logic [PC_W-1:0]  br_pc;
  fbuf_mode_e       mode;
  logic [SEQ_W-1:0] body_start, body_end;
  logic [(LANES+1)*SEQ_W-1:0] pos;
  logic [LANES*SEQ_W-1:0]     rd_pos;

  assign occ_q         = wr_q - rd_q;
  assign cnt_in        = CNT_W'($countones(fetch_valid_i));
  assign fetch_ready_o = (mode == MODE_STREAM) && (occ_q <= FILL_LIM);
  assign grp_acc       = fetch_ready_o && (|fetch_valid_i) && !flush_i;

  always_comb begin
    br_pc = '0;
    for (int j = 0; j < LANES; j++)
      if (CNT_W'(j + 1) == cnt_in) br_pc = fetch_pc_i[j*PC_W +: PC_W];
  end

  assign avail = (mode == MODE_REPLAY) ? CNT_W'(LANES) :
                 (occ_q < SEQ_W'(LANES)) ? CNT_W'(occ_q) : CNT_W'(LANES);
  assign pop_n = dec_ready_i ? avail : '0;

  for (genvar j = 0; j < LANES; j++) begin : g_dv
    assign dec_valid_o[j] = CNT_W'(j) < avail;
  end

  fbuf_rd_walk #(.LANES(LANES), .SEQ_W(SEQ_W)) u_walk (
    .rd_i    (rd_q),
    .replay_i(mode == MODE_REPLAY),
    .start_i (body_start),
    .end_i   (body_end),
    .pos_o   (pos)
  );

  assign rd_pos  = pos[LANES*SEQ_W-1:0];
  assign rd_nxt  = pos[pop_n*SEQ_W +: SEQ_W];
  assign wr_nxt  = wr_q + (grp_acc ? SEQ_W'(cnt_in) : '0);
  assign occ_nxt = wr_nxt - rd_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      wr_q <= wr_nxt;
      rd_q <= rd_nxt;
    end
  end

  fbuf_store #(
    .DEPTH(DEPTH), .LANES(LANES), .PC_W(PC_W), .INSN_W(INSN_W),
    .SEQ_W(SEQ_W), .CNT_W(CNT_W)
  ) u_store (
    .clk_i    (clk_i),
    .we_i     (grp_acc),
    .wr_seq_i (wr_q),
    .wr_cnt_i (cnt_in),
    .insn_i   (fetch_insn_i),
    .pc_i     (fetch_pc_i),
    .rd_pos_i (rd_pos),
    .rd_insn_o(dec_insn_o),
    .rd_pc_o  (dec_pc_o)
  );

  fbuf_loop_ctl #(.DEPTH(DEPTH), .PC_W(PC_W), .SEQ_W(SEQ_W)) u_loop (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .grp_acc_i   (grp_acc),
    .br_pc_i     (br_pc),
    .taken_i     (fetch_taken_i),
    .target_i    (fetch_target_i),
    .wr_nxt_i    (wr_nxt),
    .rd_q_i      (rd_q),
    .occ_q_i     (occ_q),
    .rd_nxt_i    (rd_nxt),
    .occ_nxt_i   (occ_nxt),
    .mode_o      (mode),
    .body_start_o(body_start),
    .body_end_o  (body_end)
  );

  assign icache_bypass_o = mode == MODE_REPLAY;

  logic [LANES-1:0] dv_inc;
  assign dv_inc = dec_valid_o + LANES'(1);

  // R2
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= SEQ_W'(DEPTH));

  // R3
  dec_contig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dv_inc));

  // R11
  replay_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icache_bypass_o |-> !fetch_ready_o);

  // R7
  replay_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icache_bypass_o |-> &dec_valid_o);

  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (occ_q == '0 && !icache_bypass_o && fetch_ready_o));

  // R6
  loop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(icache_bypass_o) |-> $past(grp_acc && fetch_taken_i));
endmodule

// File: tb/fetch_loop_buf_test.sv
`timescale 1ns/1ps
module fetch_loop_buf_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic [3:0]   f_valid = '0;
  logic [127:0] f_insn = '0, f_pc = '0;
  logic         f_taken = 1'b0;
  logic [31:0]  f_tgt = '0;
  logic         f_ready;
  logic [3:0]   d_valid;
  logic [127:0] d_insn, d_pc;
  logic         d_ready = 1'b0;
  logic         bypass;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mq[$];

  always #10 clk = ~clk;

  fetch_loop_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .fetch_valid_i(f_valid), .fetch_insn_i(f_insn), .fetch_pc_i(f_pc),
    .fetch_taken_i(f_taken), .fetch_target_i(f_tgt), .fetch_ready_o(f_ready),
    .dec_valid_o(d_valid), .dec_insn_o(d_insn), .dec_pc_o(d_pc),
    .dec_ready_i(d_ready), .icache_bypass_o(bypass)
  );

  // row: {lanes[2:0], dec_ready, pc[15:0]}
  localparam int NV = 24;
  localparam logic [19:0] VEC [NV] = '{
    {3'd4,1'b0,16'h1000}, {3'd3,1'b0,16'h1010}, {3'd4,1'b1,16'h101C},
    {3'd1,1'b0,16'h102C}, {3'd4,1'b0,16'h1030}, {3'd4,1'b0,16'h1040},
    {3'd4,1'b0,16'h1050}, {3'd4,1'b0,16'h1060}, {3'd4,1'b0,16'h1070},
    {3'd4,1'b0,16'h1080}, {3'd4,1'b0,16'h1090}, {3'd2,1'b1,16'h10A0},
    {3'd0,1'b1,16'h0000}, {3'd4,1'b1,16'h10B0}, {3'd2,1'b0,16'h10C0},
    {3'd0,1'b1,16'h0000}, {3'd3,1'b1,16'h10D0}, {3'd0,1'b1,16'h0000},
    {3'd0,1'b1,16'h0000}, {3'd0,1'b1,16'h0000}, {3'd0,1'b1,16'h0000},
    {3'd0,1'b1,16'h0000}, {3'd0,1'b1,16'h0000}, {3'd0,1'b1,16'h0000}
  };

  function automatic logic [31:0] insn_of(input logic [31:0] pc);
    return pc ^ 32'h5A5A_0000;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drv(input int n, input logic [31:0] pc0, input logic tk,
                     input logic [31:0] tg, input logic rdy, input logic fl);
    @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      f_valid[j] = (j < n);
      f_pc[j*32 +: 32]   = pc0 + 32'(4*j);
      f_insn[j*32 +: 32] = insn_of(pc0 + 32'(4*j));
    end
    f_taken = tk; f_tgt = tg; d_ready = rdy; flush = fl;
    #1;
  endtask

  task automatic chk_lanes(input string req, input int cnt, input logic [31:0] p0,
                           input logic [31:0] p1, input logic [31:0] p2, input logic [31:0] p3);
    logic [31:0] e [4];
    e[0] = p0; e[1] = p1; e[2] = p2; e[3] = p3;
    check(req, "dec_valid", {28'd0, d_valid}, 32'((1 << cnt) - 1));
    for (int j = 0; j < cnt; j++) begin
      check(req, "dec_pc", d_pc[j*32 +: 32], e[j]);
      check(req, "dec_insn", d_insn[j*32 +: 32], insn_of(e[j]));
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1", "ready in reset", {31'd0, f_ready}, 32'd1);
    check("R1", "valid in reset", {28'd0, d_valid}, 32'd0);
    check("R1", "bypass in reset", {31'd0, bypass}, 32'd0);
    rst_n = 1'b1;
    drv(0, 0, 0, 0, 0, 0);
    check("R1", "ready after reset", {31'd0, f_ready}, 32'd1);
    check("R1", "valid after reset", {28'd0, d_valid}, 32'd0);

    // R2 R3 R4 R5: vector walk against an in-order queue model
    for (int v = 0; v < NV; v++) begin
      int n, k;
      logic rdy, exp_rdy;
      logic [31:0] pc0;
      n = int'(VEC[v][19:17]); rdy = VEC[v][16]; pc0 = {16'h0, VEC[v][15:0]};
      drv(n, pc0, 1'b0, 0, rdy, 1'b0);
      exp_rdy = (mq.size() <= 28);
      check("R2", "fetch_ready", {31'd0, f_ready}, {31'd0, exp_rdy});
      check("R11", "bypass idle", {31'd0, bypass}, 32'd0);
      k = (mq.size() < 4) ? mq.size() : 4;
      check("R3", "lane count", {28'd0, d_valid}, 32'((1 << k) - 1));
      for (int j = 0; j < k; j++) begin
        check("R4", "order pc", d_pc[j*32 +: 32], mq[j]);
        check("R4", "order insn", d_insn[j*32 +: 32], insn_of(mq[j]));
      end
      if (rdy) for (int j = 0; j < k; j++) void'(mq.pop_front());
      if (exp_rdy) for (int j = 0; j < n; j++) mq.push_back(pc0 + 32'(4*j));
      else if (n > 0) check("R5", "group offered while full dropped", 32'd1, 32'd1);
    end
    check("R5", "model drained", 32'(mq.size()), 32'd0);

    // R6 R7 R11 R10: four-entry body
    drv(0, 0, 0, 0, 0, 1);
    drv(4, 32'h100, 1, 32'h100, 0, 0);
    drv(4, 32'h100, 1, 32'h100, 0, 0);
    check("R6", "no replay after first sighting", {31'd0, bypass}, 32'd0);
    drv(4, 32'h900, 0, 0, 1, 0);
    check("R6", "bypass on", {31'd0, bypass}, 32'd1);
    check("R6", "fetch stopped", {31'd0, f_ready}, 32'd0);
    chk_lanes("R7", 4, 32'h100, 32'h104, 32'h108, 32'h10C);
    drv(4, 32'h900, 0, 0, 1, 0);
    chk_lanes("R7", 4, 32'h100, 32'h104, 32'h108, 32'h10C);
    drv(0, 0, 0, 0, 1, 0);
    chk_lanes("R11", 4, 32'h100, 32'h104, 32'h108, 32'h10C);
    drv(4, 32'h900, 0, 0, 1, 1);
    drv(0, 0, 0, 0, 0, 0);
    check("R10", "bypass cleared", {31'd0, bypass}, 32'd0);
    check("R10", "fetch ready", {31'd0, f_ready}, 32'd1);
    check("R10", "queue empty, flushed group dropped", {28'd0, d_valid}, 32'd0);

    // R7: three-entry body wraps inside one output cycle
    drv(3, 32'h200, 1, 32'h200, 0, 0);
    drv(3, 32'h200, 1, 32'h200, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    chk_lanes("R7", 4, 32'h200, 32'h204, 32'h208, 32'h200);
    drv(0, 0, 0, 0, 1, 0);
    chk_lanes("R7", 4, 32'h204, 32'h208, 32'h200, 32'h204);
    drv(0, 0, 0, 0, 0, 0);
    chk_lanes("R7", 4, 32'h208, 32'h200, 32'h204, 32'h208);
    drv(0, 0, 0, 0, 0, 1);

    // R8: forward taken branch between sightings
    drv(4, 32'h300, 1, 32'h300, 0, 0);
    drv(4, 32'h300, 1, 32'h500, 0, 0);
    drv(4, 32'h300, 1, 32'h300, 0, 0);
    drv(0, 0, 0, 0, 0, 0);
    check("R8", "no replay after forward branch", {31'd0, bypass}, 32'd0);
    check("R8", "still fetching", {31'd0, f_ready}, 32'd1);
    drv(4, 32'h300, 1, 32'h300, 0, 0);
    drv(0, 0, 0, 0, 0, 0);
    check("R6", "replay after fresh pair", {31'd0, bypass}, 32'd1);
    drv(0, 0, 0, 0, 0, 1);

    // R9: target consumed before the second sighting
    drv(4, 32'h600, 1, 32'h600, 0, 0);
    drv(4, 32'h600, 0, 0, 0, 0);
    drv(0, 0, 0, 0, 1, 0);
    drv(0, 0, 0, 0, 1, 0);
    drv(4, 32'h600, 1, 32'h600, 0, 0);
    drv(0, 0, 0, 0, 0, 0);
    check("R9", "no replay", {31'd0, bypass}, 32'd0);
    check("R9", "fetch ready", {31'd0, f_ready}, 32'd1);
    chk_lanes("R9", 4, 32'h600, 32'h604, 32'h608, 32'h60C);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule